// File: doc/BRIEF.md
# Eight-Instruction Accumulator Processor

A multicycle processor built around one 8-bit accumulator and a 32-byte memory that holds both the program and its data. Every instruction is one byte. The top three bits select one of eight operations and the low five bits name a memory location. The core runs each instruction as a fixed series of register transfers through a program counter, an instruction register, a memory address register, a memory data register and the accumulator. Each transfer takes one clock.

After a synchronous reset, execution begins at the address on `start_pc`. The core runs until it decodes a halt instruction. It then raises `halted` and freezes every register and every memory location until the next reset. Memory is never cleared by reset. The surrounding environment places the program image in the internal array while reset is held. Progress can be observed on a debug view of the accumulator and the program counter.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_dbg` takes the value of `start_pc`, `acc_dbg` becomes 0 and `halted` becomes 0.
- R2: Instruction bits [7:5] hold the opcode and bits [4:0] hold an address. The opcodes are: 000 halt, 001 load, 010 store, 011 add, 100 subtract, 101 jump, 110 jump-if-zero, 111 jump-if-positive. Every fetch advances the program counter by one.
- R3: Load copies the byte at the addressed location into the accumulator.
- R4: Add replaces the accumulator with the accumulator plus the addressed byte, modulo 256.
- R5: Subtract replaces the accumulator with the accumulator minus the addressed byte, modulo 256.
- R6: Store writes the accumulator to the addressed location. A later load of that location returns the stored value, including a load made after another reset.
- R7: Jump always loads the program counter with the address field.
- R8: Jump-if-zero loads the program counter with the address field only when the accumulator is 0. Otherwise the incremented program counter is kept.
- R9: Jump-if-positive loads the program counter only when accumulator bit 7 is 0 and the accumulator is nonzero. Otherwise the incremented program counter is kept.
- R10: Halt raises `halted`. `pc_dbg` is left one past the halt instruction. From then on, `halted`, the accumulator, the program counter and memory hold their values until reset.
- R11: The program counter wraps from 31 to 0.
- R12: With +5 at location 8 and -3 (0xFD) at location 9, the program load 8, add 9, store 10, halt, placed at locations 4 to 7, leaves 2 at location 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_pc | input | 5 | Address of the first instruction after reset |
| halted | output | 1 | High once a halt instruction has executed |
| acc_dbg | output | 8 | Current accumulator value |
| pc_dbg | output | 5 | Current program counter value |

## Verification
The bench builds the core with the package defaults: an 8-bit word, a 5-bit address and a 3-bit opcode. This puts all 32 memory locations in use. It also lets a program start at location 31, so the wrap of the program counter to 0 can be observed. Because the word is 8 bits wide, sums and differences that cross 127 and 255 show both the sign bit and the modulo-256 wrap. The conditional jumps are tested with accumulator values that are zero, small positive, 0x7F and 0x80.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int unsigned WORD_W    = 8;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned OPC_W     = WORD_W - ADDR_W;
    localparam int unsigned MEM_DEPTH = 1 << ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_ADD   = 3'd3,
        OP_SUB   = 3'd4,
        OP_JUMP  = 3'd5,
        OP_JZERO = 3'd6,
        OP_JPOS  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        PH_FETCH_A,
        PH_FETCH_R,
        PH_DECODE,
        PH_OPER_A,
        PH_OPER_R,
        PH_EXEC,
        PH_STORE_W,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic mar_pc;
        logic mar_ir;
        logic mdr_mem;
        logic mdr_acc;
        logic ir_ld;
        logic pc_inc;
        logic pc_jump;
        logic acc_ld;
        logic acc_add;
        logic acc_sub;
        logic mem_we;
    } ctl_t;

    function automatic opcode_e op_of(input word_t w);
        return opcode_e'(w[WORD_W-1 -: OPC_W]);
    endfunction

    function automatic addr_t addr_of(input word_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic logic take_branch(input opcode_e op, input word_t acc);
        case (op)
            OP_JUMP:  return 1'b1;
            OP_JZERO: return (acc == '0);
            OP_JPOS:  return (!acc[WORD_W-1]) && (acc != '0);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t addr,
    input  word_t wdata,
    output word_t rdata
);
    word_t cells [MEM_DEPTH];

    // Memory is never cleared; writes are blocked while reset is held.
    always_ff @(posedge clk) begin
        if (we && !rst) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

    // R6: a write lands at the addressed location
    a_r6_store_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (cells[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t mdr,
    input  word_t ir,
    input  word_t acc,
    output ctl_t  ctl,
    output logic  halted
);
    phase_e phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_FETCH_A;
        else     phase_q <= phase_d;
    end

    always_comb begin
        ctl     = '0;
        phase_d = phase_q;
        case (phase_q)
            PH_FETCH_A: begin
                ctl.mar_pc = 1'b1;
                phase_d    = PH_FETCH_R;
            end
            PH_FETCH_R: begin
                ctl.mdr_mem = 1'b1;
                phase_d     = PH_DECODE;
            end
            PH_DECODE: begin
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
                case (op_of(mdr))
                    OP_HALT:                            phase_d = PH_STOP;
                    OP_LOAD, OP_STORE, OP_ADD, OP_SUB:  phase_d = PH_OPER_A;
                    default:                            phase_d = PH_EXEC;
                endcase
            end
            PH_OPER_A: begin
                ctl.mar_ir = 1'b1;
                if (op_of(ir) == OP_STORE) begin
                    ctl.mdr_acc = 1'b1;
                    phase_d     = PH_STORE_W;
                end else begin
                    phase_d     = PH_OPER_R;
                end
            end
            PH_OPER_R: begin
                ctl.mdr_mem = 1'b1;
                phase_d     = PH_EXEC;
            end
            PH_EXEC: begin
                case (op_of(ir))
                    OP_LOAD: ctl.acc_ld  = 1'b1;
                    OP_ADD:  ctl.acc_add = 1'b1;
                    OP_SUB:  ctl.acc_sub = 1'b1;
                    default: ctl.pc_jump = take_branch(op_of(ir), acc);
                endcase
                phase_d = PH_FETCH_A;
            end
            PH_STORE_W: begin
                ctl.mem_we = 1'b1;
                phase_d    = PH_FETCH_A;
            end
            default: phase_d = PH_STOP;
        endcase
    end

    assign halted = (phase_q == PH_STOP);

    // R10: once stopped, stays stopped until reset
    a_r10_stop_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R2: decode always follows the fetch read
    a_r2_decode_order: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH_R) |=> (phase_q == PH_DECODE));

    // R10: no memory write while stopped
    a_r10_no_write_stopped: assert property (@(posedge clk) disable iff (rst)
        halted |-> !ctl.mem_we);

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t start_pc,
    input  ctl_t  ctl,
    input  word_t mem_rdata,
    output addr_t mar,
    output word_t mdr,
    output word_t ir,
    output word_t acc,
    output addr_t pc
);
    localparam addr_t PC_ONE = addr_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= start_pc;
            acc <= '0;
            mar <= '0;
            mdr <= '0;
            ir  <= '0;
        end else begin
            if (ctl.mar_pc)       mar <= pc;
            else if (ctl.mar_ir)  mar <= addr_of(ir);

            if (ctl.mdr_mem)      mdr <= mem_rdata;
            else if (ctl.mdr_acc) mdr <= acc;

            if (ctl.ir_ld)        ir  <= mdr;

            if (ctl.pc_jump)      pc  <= addr_of(ir);
            else if (ctl.pc_inc)  pc  <= pc + PC_ONE;

            if (ctl.acc_ld)       acc <= mdr;
            else if (ctl.acc_add) acc <= acc + mdr;
            else if (ctl.acc_sub) acc <= acc - mdr;
        end
    end

    // R4: sum wraps modulo 256
    a_r4_add_wraps: assert property (@(posedge clk) disable iff (rst)
        ctl.acc_add |=> (acc == word_t'($past(acc) + $past(mdr))));

    // R5: difference wraps modulo 256
    a_r5_sub_wraps: assert property (@(posedge clk) disable iff (rst)
        ctl.acc_sub |=> (acc == word_t'($past(acc) - $past(mdr))));

    // R11: increment wraps from the top address to 0
    a_r11_pc_wrap: assert property (@(posedge clk) disable iff (rst)
        (ctl.pc_inc && !ctl.pc_jump && (pc == '1)) |=> (pc == '0));

    // R7: a taken jump lands on the address field
    a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_jump |=> (pc == addr_of($past(ir))));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] start_pc,
    output logic              halted,
    output logic [WORD_W-1:0] acc_dbg,
    output logic [ADDR_W-1:0] pc_dbg
);
    ctl_t  ctl;
    addr_t mar;
    addr_t pc;
    word_t mdr;
    word_t ir;
    word_t acc;
    word_t mem_rdata;

    acc_cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .mdr    (mdr),
        .ir     (ir),
        .acc    (acc),
        .ctl    (ctl),
        .halted (halted)
    );

    acc_cpu_dp u_dp (
        .clk       (clk),
        .rst       (rst),
        .start_pc  (start_pc),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar       (mar),
        .mdr       (mdr),
        .ir        (ir),
        .acc       (acc),
        .pc        (pc)
    );

    acc_cpu_mem u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.mem_we),
        .addr  (mar),
        .wdata (mdr),
        .rdata (mem_rdata)
    );

    assign acc_dbg = acc;
    assign pc_dbg  = pc;

    // R10: visible state frozen while halted
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(acc_dbg) && $stable(pc_dbg)));

endmodule

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
    import acc_cpu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] start_pc = '0;
    logic       halted;
    logic [7:0] acc_dbg;
    logic [4:0] pc_dbg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    acc_cpu dut_i (
        .clk      (clk),
        .rst      (rst),
        .start_pc (start_pc),
        .halted   (halted),
        .acc_dbg  (acc_dbg),
        .pc_dbg   (pc_dbg)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] exp_acc;
        logic [4:0] exp_pc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 8'h09, 8'h5A, 8'h5A, 5'd6},  // R3 load
        '{3'd3, 8'h05, 8'hFD, 8'h02, 5'd6},  // R4 5 + -3
        '{3'd3, 8'hF0, 8'h20, 8'h10, 5'd6},  // R4 wrap past 255
        '{3'd3, 8'h7F, 8'h01, 8'h80, 5'd6},  // R4 into sign bit
        '{3'd4, 8'h05, 8'h03, 8'h02, 5'd6},  // R5
        '{3'd4, 8'h03, 8'h05, 8'hFE, 5'd6},  // R5 negative result
        '{3'd4, 8'h80, 8'h01, 8'h7F, 5'd6},  // R5 wrap below -128
        '{3'd5, 8'h00, 8'h00, 8'h44, 5'd6},  // R7
        '{3'd6, 8'h00, 8'h00, 8'h44, 5'd6},  // R8 taken
        '{3'd6, 8'h01, 8'h00, 8'h33, 5'd4},  // R8 not taken
        '{3'd7, 8'h01, 8'h00, 8'h44, 5'd6},  // R9 taken
        '{3'd7, 8'h00, 8'h00, 8'h33, 5'd4},  // R9 zero not taken
        '{3'd7, 8'h80, 8'h00, 8'h33, 5'd4},  // R9 negative not taken
        '{3'd7, 8'h7F, 8'h00, 8'h44, 5'd6}   // R9 largest positive
    };

    function automatic logic [7:0] enc(input logic [2:0] op, input logic [4:0] a);
        return {op, a};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] v);
        dut_i.u_mem.cells[a] <= v;
    endtask

    task automatic begin_run(input logic [4:0] sp, input logic clear);
        @(negedge clk);
        rst      = 1'b1;
        start_pc = sp;
        repeat (2) @(negedge clk);
        if (clear) begin
            for (int i = 0; i < 32; i++) poke(i, 8'h00);
        end
        #1;
    endtask

    task automatic finish_run(input string tag);
        bit done;
        done = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (halted) begin
                done = 1'b1;
                break;
            end
        end
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL %s no halt actual=0 expected=1", tag);
        end
    endtask

    initial begin
        logic [7:0] acc_keep;
        logic [4:0] pc_keep;

        // R1 reset state and R12 sample program at locations 4..7
        begin_run(5'd4, 1'b1);
        check("R1 pc_dbg after reset", 32'(pc_dbg), 32'd4);
        check("R1 acc_dbg after reset", 32'(acc_dbg), 32'd0);
        check("R1 halted after reset", 32'(halted), 32'd0);
        poke(4, enc(OP_LOAD, 5'd8));
        poke(5, enc(OP_ADD, 5'd9));
        poke(6, enc(OP_STORE, 5'd10));
        poke(7, enc(OP_HALT, 5'd0));
        poke(8, 8'h05);
        poke(9, 8'hFD);
        #1;
        finish_run("R12 sample");
        check("R12 sample acc", 32'(acc_dbg), 32'd2);
        check("R10 pc one past halt", 32'(pc_dbg), 32'd8);

        // R10 frozen while halted
        acc_keep = acc_dbg;
        pc_keep  = pc_dbg;
        repeat (25) @(negedge clk);
        check("R10 halted held", 32'(halted), 32'd1);
        check("R10 acc frozen", 32'(acc_dbg), 32'(acc_keep));
        check("R10 pc frozen", 32'(pc_dbg), 32'(pc_keep));

        // R6/R12 location 10 survives reset; read it back by a new program
        begin_run(5'd12, 1'b0);
        check("R1 halted cleared by reset", 32'(halted), 32'd0);
        check("R1 acc cleared by reset", 32'(acc_dbg), 32'd0);
        poke(12, enc(OP_LOAD, 5'd10));
        poke(13, enc(OP_HALT, 5'd0));
        #1;
        finish_run("R6 readback");
        check("R6 R12 location 10 holds 2", 32'(acc_dbg), 32'd2);
        check("R2 pc after readback", 32'(pc_dbg), 32'd14);

        // Vector table: arithmetic programs and jump programs
        for (int v = 0; v < NV; v++) begin
            begin_run(5'd0, 1'b1);
            if (VECS[v].op inside {3'd1, 3'd3, 3'd4}) begin
                poke(0, enc(OP_LOAD, 5'd20));
                poke(1, enc(VECS[v].op, 5'd21));
                poke(2, enc(OP_STORE, 5'd22));
                poke(3, enc(OP_LOAD, 5'd23));
                poke(4, enc(OP_LOAD, 5'd22));
                poke(5, enc(OP_HALT, 5'd0));
                poke(20, VECS[v].a);
                poke(21, VECS[v].b);
                poke(23, 8'h77);
            end else begin
                poke(0, enc(OP_LOAD, 5'd20));
                poke(1, enc(VECS[v].op, 5'd4));
                poke(2, enc(OP_LOAD, 5'd21));
                poke(3, enc(OP_HALT, 5'd0));
                poke(4, enc(OP_LOAD, 5'd22));
                poke(5, enc(OP_HALT, 5'd0));
                poke(20, VECS[v].a);
                poke(21, 8'h33);
                poke(22, 8'h44);
            end
            #1;
            finish_run($sformatf("vector %0d", v));
            check($sformatf("R3-R9 vector %0d acc (R3 R4 R5 R6 R7 R8 R9)", v),
                  32'(acc_dbg), 32'(VECS[v].exp_acc));
            check($sformatf("R2 vector %0d pc", v), 32'(pc_dbg), 32'(VECS[v].exp_pc));
        end

        // R11 program counter wraps from 31 to 0
        begin_run(5'd31, 1'b1);
        poke(31, enc(OP_LOAD, 5'd20));
        poke(0, enc(OP_HALT, 5'd0));
        poke(20, 8'h5C);
        #1;
        finish_run("R11 wrap");
        check("R11 acc after wrap", 32'(acc_dbg), 32'h5C);
        check("R11 pc after wrap", 32'(pc_dbg), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule